// File: doc/BRIEF.md
# Gated 13-bit Timer/Counter

This block is one channel of a small timer that counts in a 13-bit register. The register is exposed as two bytes. The high byte supplies all eight upper bits. The low byte supplies only its bottom five bits, and its top three bits always read as zero.

The count source is chosen by a select bit. When the bit is clear, the channel counts a one-cycle tick strobe from a prescaler outside the block. When the bit is set, it counts falling edges on an asynchronous count pin. An increment is accepted only while the run bit is set. When gating is enabled, the gate pin must also be high.

When the count passes from all ones back to zero, the channel sets an overflow flag and can invert a toggle output. Software clears the flag, or the interrupt acknowledge clears it. A software write to either byte loads that part of the count directly.

Top module: `tmr13_gated`

## Requirements
- R1: The count is 13 bits: hi_o[7:0] holds count bits 12..5 and lo_o[4:0] holds bits 4..0. Each accepted event adds one, and the carry passes from lo_o[4:0]=0x1F into hi_o.
- R2: lo_o[7:5] always reads 0, including after a write with those bits set. A low-byte write stores only wdata_i[4:0].
- R3: An accepted event at count 0x1FFF wraps the count to 0 and sets ovf_flag_o on that same clock edge.
- R4: An event is accepted only when run_i=1 and either gate_en_i=0 or gate_pin_i=1. Otherwise the count holds its value.
- R5: Clearing and then setting run_i keeps the held count, and counting resumes from it.
- R6: With ext_sel_i=0, each cycle with tick_i=1 adds one at that clock edge. With ext_sel_i=1, tick_i is ignored. Each falling edge of cnt_pin_i adds exactly one, and the count shows it on the third rising clock edge after the fall.
- R7: flag_clr_i=1 clears ovf_flag_o at the next edge.
- R8: On overflow, tgl_o inverts when tgl_en_i=1 and holds its value when tgl_en_i=0.
- R9: A write (wr_hi_i or wr_lo_i) takes priority over an increment in the same cycle, and the written value is loaded.
- R10: When an overflow and flag_clr_i occur in the same cycle, ovf_flag_o ends up set.
- R11: Reset (rst_n=0) clears the count, ovf_flag_o and tgl_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal prescaled tick strobe |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| gate_pin_i | input | 1 | Gate pin |
| run_i | input | 1 | Run control |
| gate_en_i | input | 1 | Enables gating by gate_pin_i |
| ext_sel_i | input | 1 | 0 = count ticks, 1 = count pin falls |
| tgl_en_i | input | 1 | Toggle-on-overflow enable |
| wr_hi_i | input | 1 | Write strobe for the high byte |
| wr_lo_i | input | 1 | Write strobe for the low byte |
| wdata_i | input | 8 | Write data |
| flag_clr_i | input | 1 | Overflow flag clear (software or acknowledge) |
| hi_o | output | 8 | High count byte |
| lo_o | output | 8 | Low count byte, top 3 bits zero |
| ovf_flag_o | output | 1 | Overflow flag |
| tgl_o | output | 1 | Toggle output |

## Verification
A corrupted count register appears on hi_o and lo_o at the next sampling point, because both bytes are plain views of the register. A wrong carry or wrap point stays hidden until the count reaches 0x1F or 0x1FFF. That is why the bench loads values near those boundaries and then applies a single event. A fault in the synchronizer or edge detector appears as a missing increment, a doubled increment or a shifted one, three edges after a pin fall. A fault in the qualifier appears as the count moving while it should be held.

// File: rtl/tmr13_gated.sv
module tmr13_gated #(
  parameter int HI_W = 8,
  parameter int LO_W = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              gate_pin_i,
  input  logic              run_i,
  input  logic              gate_en_i,
  input  logic              ext_sel_i,
  input  logic              tgl_en_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              flag_clr_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic              ovf_flag_o,
  output logic              tgl_o
);
  localparam int CW = HI_W + LO_W;

  logic [CW-1:0] cnt_q;
  logic [2:0]    pin_sync_q;
  logic          pin_fall, evt, qual, inc, wr_any, wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync_q <= '1;
    else        pin_sync_q <= {pin_sync_q[1:0], cnt_pin_i};

  assign pin_fall = pin_sync_q[2] & ~pin_sync_q[1];
  assign evt      = ext_sel_i ? pin_fall : tick_i;
  assign qual     = run_i & (~gate_en_i | gate_pin_i);
  assign wr_any   = wr_hi_i | wr_lo_i;
  assign inc      = evt & qual & ~wr_any;
  assign wrap     = inc & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else if (wr_any) begin
      if (wr_hi_i) cnt_q[CW-1:LO_W] <= wdata_i[HI_W-1:0];
      if (wr_lo_i) cnt_q[LO_W-1:0]  <= wdata_i[LO_W-1:0];
    end
    else if (inc) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_flag_o <= 1'b0;
      tgl_o      <= 1'b0;
    end else begin
      if (wrap)            ovf_flag_o <= 1'b1;
      else if (flag_clr_i) ovf_flag_o <= 1'b0;
      if (wrap && tgl_en_i) tgl_o <= ~tgl_o;
    end

  assign hi_o = BYTE_W'(cnt_q[CW-1:LO_W]);
  assign lo_o = BYTE_W'(cnt_q[LO_W-1:0]);
endmodule

// File: rtl/tmr13_gated_chk.sv
module tmr13_gated_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_i,
  input logic       gate_en_i,
  input logic       gate_pin_i,
  input logic       wr_hi_i,
  input logic       wr_lo_i,
  input logic       tgl_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] hi_o,
  input logic [7:0] lo_o,
  input logic       ovf_flag_o,
  input logic       tgl_o
);
  // R3
  flag_rise_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> ($past(hi_o) == 8'hFF && $past(lo_o[4:0]) == 5'h1F && hi_o == 8'h00 && lo_o == 8'h00));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_hi_i && !wr_lo_i) |=> $stable({hi_o, lo_o}));

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_i && !gate_pin_i && !wr_hi_i && !wr_lo_i) |=> $stable({hi_o, lo_o}));

  // R9
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_i |=> (hi_o == $past(wdata_i)));

  // R8
  tgl_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgl_o) |-> ($rose(ovf_flag_o) || ovf_flag_o) && $past(tgl_en_i) && hi_o == 8'h00);
endmodule

bind tmr13_gated tmr13_gated_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .gate_en_i(gate_en_i),
  .gate_pin_i(gate_pin_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
  .tgl_en_i(tgl_en_i), .wdata_i(wdata_i), .hi_o(hi_o), .lo_o(lo_o),
  .ovf_flag_o(ovf_flag_o), .tgl_o(tgl_o)
);

// File: tb/test_tmr13_gated.sv
module test_tmr13_gated;
  logic clk = 0, rst_n = 0;
  logic tick_i = 0, cnt_pin_i = 1, gate_pin_i = 0, run_i = 0, gate_en_i = 0;
  logic ext_sel_i = 0, tgl_en_i = 0, wr_hi_i = 0, wr_lo_i = 0, flag_clr_i = 0;
  logic [7:0] wdata_i = 0, hi_o, lo_o;
  logic ovf_flag_o, tgl_o;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr13_gated i_tmr13_gated (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit hi, logic [7:0] d);
    wr_hi_i = hi; wr_lo_i = !hi; wdata_i = d;
    @(posedge clk); @(negedge clk);
    wr_hi_i = 0; wr_lo_i = 0;
  endtask

  task automatic ticks(int n);
    tick_i = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_i = 0;
  endtask

  task automatic t_reset;
    chk("R11 count", {hi_o, lo_o}, 16'h0000);
    chk("R11 flag", 16'(ovf_flag_o), 16'h0);
    chk("R11 tgl", 16'(tgl_o), 16'h0);
  endtask

  task automatic t_tick;
    run_i = 1; ext_sel_i = 0;
    ticks(5);
    chk("R6 tick count", {hi_o, lo_o}, 16'h0005);
  endtask

  task automatic t_carry;
    wr(1, 8'h12); wr(0, 8'hFF);
    chk("R2 upper low bits zero", 16'(lo_o), 16'h001F);
    ticks(1);
    chk("R1 carry into high", {hi_o, lo_o}, 16'h1300);
  endtask

  task automatic t_gate;
    gate_en_i = 1; gate_pin_i = 0;
    ticks(4);
    chk("R4 gate low holds", {hi_o, lo_o}, 16'h1300);
    gate_pin_i = 1;
    ticks(3);
    chk("R4 gate high counts", {hi_o, lo_o}, 16'h1303);
    run_i = 0;
    ticks(4);
    chk("R4 run low holds", {hi_o, lo_o}, 16'h1303);
    run_i = 1; gate_en_i = 0; gate_pin_i = 0;
    ticks(2);
    chk("R5 resume from held", {hi_o, lo_o}, 16'h1305);
  endtask

  task automatic t_ovf;
    tgl_en_i = 0;
    wr(1, 8'hFF); wr(0, 8'h1F);
    ticks(1);
    chk("R3 wrap to zero", {hi_o, lo_o}, 16'h0000);
    chk("R3 flag set", 16'(ovf_flag_o), 16'h1);
    chk("R8 no toggle when disabled", 16'(tgl_o), 16'h0);
    flag_clr_i = 1; @(posedge clk); @(negedge clk); flag_clr_i = 0;
    chk("R7 flag cleared", 16'(ovf_flag_o), 16'h0);
    tgl_en_i = 1;
    wr(1, 8'hFF); wr(0, 8'h1F);
    ticks(1);
    chk("R8 toggle on wrap", 16'(tgl_o), 16'h1);
    tgl_en_i = 0;
  endtask

  task automatic t_collide;
    flag_clr_i = 1; @(posedge clk); @(negedge clk); flag_clr_i = 0;
    wr(1, 8'hFF); wr(0, 8'h1F);
    tick_i = 1; flag_clr_i = 1;
    @(posedge clk); @(negedge clk);
    tick_i = 0; flag_clr_i = 0;
    chk("R10 set wins over clear", 16'(ovf_flag_o), 16'h1);
  endtask

  task automatic t_ext;
    wr(1, 8'h00); wr(0, 8'h00);
    ext_sel_i = 1; tick_i = 1;
    repeat (4) @(negedge clk);
    chk("R6 tick ignored in pin mode", {hi_o, lo_o}, 16'h0000);
    cnt_pin_i = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 not yet counted", {hi_o, lo_o}, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R6 counted at third edge", {hi_o, lo_o}, 16'h0001);
    repeat (3) @(negedge clk);
    cnt_pin_i = 1;
    for (int k = 0; k < 2; k++) begin
      repeat (4) @(negedge clk);
      cnt_pin_i = 0;
      repeat (4) @(negedge clk);
      cnt_pin_i = 1;
    end
    repeat (4) @(negedge clk);
    chk("R6 one per fall", {hi_o, lo_o}, 16'h0003);
    tick_i = 0; ext_sel_i = 0;
  endtask

  task automatic t_prio;
    wr(0, 8'h00);
    tick_i = 1;
    @(negedge clk);
    wr(0, 8'h0A);
    chk("R9 write beats increment", {hi_o, lo_o}, 16'h000A);
    tick_i = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      begin
        t_reset; t_tick; t_carry; t_gate; t_ovf; t_collide; t_ext; t_prio;
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule